// File: doc/BRIEF.md
# Saturating Flag ALU

This block is a 32-bit integer arithmetic and logic unit. It adds, subtracts in either operand order, compares, and runs saturating versions of the three arithmetic forms. It also does bitwise AND, OR, XOR, NOT and a flag-only AND test. Every operation updates a five-bit status word that the block holds: zero, sign, overflow, carry and a sticky saturation bit. Each operation class changes its own subset of those bits and leaves the rest alone.

The first operand is either the `srcA` register value or an immediate built from `immVal`. The immediate can be 5 bits sign-extended, 16 bits sign-extended or 16 bits zero-extended. The second operand is always `srcB`. An operation presented with `inValid` high is captured on the next rising clock edge. From that edge on, `resultOut`, `writeEn` and `flagsOut` show its outcome. `writeEn` marks the cycles in which a register-file write should take place.

Top module: `sat_flag_alu`

## Requirements
- R1: Opcode 0 (add) yields opA+opB, opcode 1 (subtract) yields opB-opA and opcode 2 (reverse subtract) yields opA-opB, all modulo 2^32. The result and `writeEn`=1 appear on the clock edge that captures `inValid`. `writeEn` is 0 in every other cycle.
- R2: Opcode 3 (compare) updates Z, S, OV and CY exactly as subtract does. It leaves `writeEn` at 0 and `resultOut` unchanged.
- R3: OV is set on add when both operands have the same sign and the raw sum's sign differs from it. On a subtraction OV is set when minuend and subtrahend differ in sign and the raw difference's sign differs from the minuend's.
- R4: CY is the carry out of bit 31 on add and the unsigned borrow on any subtraction. `flagsOut` bit 0 is Z, bit 1 is S, bit 2 is OV, bit 3 is CY and bit 4 is SAT.
- R5: Opcodes 4, 5 and 6 are saturating add, subtract and reverse subtract. When such an operation overflows, its result is 0x80000000 if the minuend (for add, opA) is negative and 0x7FFFFFFF otherwise. Z and S then describe the raw wrapped value.
- R6: SAT is set by a saturating overflow. No other operation clears it. Only reset clears it.
- R7: Opcodes 7, 8, 9 and 10 (AND, OR, XOR, NOT of opA) write their result. They set Z and S from it, clear OV and keep CY. Opcode 11 (test) updates flags from AND and does not write.
- R8: AND with the zero-extended 16-bit immediate updates Z, forces S and OV to 0 and keeps CY.
- R9: `immMode` 0 selects `srcA`, 1 selects `immVal[4:0]` sign-extended, 2 selects `immVal` sign-extended and 3 selects `immVal` zero-extended. The selected value becomes opA.
- R10: A cycle with `inValid` low, or with an opcode from 12 to 15, changes neither flags nor result, and `writeEn` is 0.
- R11: Reset forces `resultOut`, `writeEn` and `flagsOut` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand |
| immVal | input | 16 | Immediate field |
| immMode | input | 2 | First-operand source and extension |
| resultOut | output | 32 | Registered result |
| writeEn | output | 1 | Result should be written this cycle |
| flagsOut | output | 5 | Held status word {SAT,CY,OV,S,Z} |

## Verification
The hardest behaviour to reach from the ports is the history of the status word. Three cases depend on it: a kept CY after a logical operation, a sticky SAT after later clean operations, and a reverse-subtract clamp whose minuend is positive. None of these shows up in a single isolated operation. The stimulus is therefore one ordered vector sequence, and each vector's expected flags include the carry and saturation state left by the vectors before it. Saturating overflows with a negative and with a positive minuend are placed ahead of logical, test and unused-opcode vectors, so that those later vectors can show both bits being kept.

// File: rtl/satalu_pkg.sv
package satalu_pkg;
  localparam int FLAG_W = 5;
  localparam int FZ   = 0;
  localparam int FS   = 1;
  localparam int FOV  = 2;
  localparam int FCY  = 3;
  localparam int FSAT = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_RSUB  = 4'd2,  OP_CMP = 4'd3,
    OP_SADD = 4'd4,  OP_SSUB = 4'd5,  OP_SRSUB = 4'd6,  OP_AND = 4'd7,
    OP_OR   = 4'd8,  OP_XOR  = 4'd9,  OP_NOT   = 4'd10, OP_TST = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0, SRC_SX5 = 2'd1, SRC_SX16 = 2'd2, SRC_ZX16 = 2'd3
  } srcMode_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOTA = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      valid;
    logic      doArith;
    logic      subMode;
    logic      minuendA;
    logic      satEn;
    logic      doLogic;
    logicSel_e logicSel;
    logic      zOnly;
    logic      writeRes;
  } strobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import satalu_pkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opCode,
  input  logic [1:0] immMode,
  output strobe_t    stb
);
  always_comb begin
    stb          = '0;
    stb.logicSel = LG_AND;
    if (inValid) begin
      unique case (opCode)
        OP_ADD, OP_SADD: begin
          stb.valid = 1'b1; stb.doArith = 1'b1; stb.writeRes = 1'b1;
          stb.satEn = (opCode == OP_SADD);
        end
        OP_SUB, OP_SSUB: begin
          stb.valid = 1'b1; stb.doArith = 1'b1; stb.subMode = 1'b1;
          stb.writeRes = 1'b1; stb.satEn = (opCode == OP_SSUB);
        end
        OP_RSUB, OP_SRSUB: begin
          stb.valid = 1'b1; stb.doArith = 1'b1; stb.subMode = 1'b1;
          stb.minuendA = 1'b1; stb.writeRes = 1'b1;
          stb.satEn = (opCode == OP_SRSUB);
        end
        OP_CMP: begin
          stb.valid = 1'b1; stb.doArith = 1'b1; stb.subMode = 1'b1;
        end
        OP_AND: begin
          stb.valid = 1'b1; stb.doLogic = 1'b1; stb.writeRes = 1'b1;
          stb.zOnly = (immMode == SRC_ZX16);
        end
        OP_OR: begin
          stb.valid = 1'b1; stb.doLogic = 1'b1; stb.writeRes = 1'b1;
          stb.logicSel = LG_OR;
        end
        OP_XOR: begin
          stb.valid = 1'b1; stb.doLogic = 1'b1; stb.writeRes = 1'b1;
          stb.logicSel = LG_XOR;
        end
        OP_NOT: begin
          stb.valid = 1'b1; stb.doLogic = 1'b1; stb.writeRes = 1'b1;
          stb.logicSel = LG_NOTA;
        end
        OP_TST: begin
          stb.valid = 1'b1; stb.doLogic = 1'b1;
        end
        default: stb = '0;
      endcase
    end
  end

  // R10: only decoded opcodes raise any strobe
  always_comb begin
    if (inValid && opCode > 4'd11)
      p_unused_quiet_r10: assert (!stb.valid && !stb.writeRes);
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import satalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [1:0]        immMode,
  output logic [DATA_W-1:0] resultQ,
  output logic              wenQ,
  output logic [FLAG_W-1:0] flagsQ
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] opA, opB, minuend, subtrahend, rawArith, logicRes, clampVal;
  logic [DATA_W:0]   wide;
  logic              ovRaw, cyRaw, satHit, clampNeg;
  logic [DATA_W-1:0] nextResult;
  logic [FLAG_W-1:0] nextFlags;
  logic              satHitQ;

  always_comb begin
    unique case (srcMode_e'(immMode))
      SRC_SX5:  opA = {{(DATA_W-SHORT_W){immVal[SHORT_W-1]}}, immVal[SHORT_W-1:0]};
      SRC_SX16: opA = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
      SRC_ZX16: opA = {{(DATA_W-IMM_W){1'b0}}, immVal};
      default:  opA = srcA;
    endcase
  end
  assign opB = srcB;

  always_comb begin
    minuend    = stb.minuendA ? opA : opB;
    subtrahend = stb.minuendA ? opB : opA;
    if (stb.subMode) begin
      wide  = {1'b0, minuend} - {1'b0, subtrahend};
      ovRaw = (minuend[MSB] != subtrahend[MSB]) && (wide[MSB] != minuend[MSB]);
      clampNeg = minuend[MSB];
    end else begin
      wide  = {1'b0, opA} + {1'b0, opB};
      ovRaw = (opA[MSB] == opB[MSB]) && (wide[MSB] != opA[MSB]);
      clampNeg = opA[MSB];
    end
    rawArith = wide[MSB:0];
    cyRaw    = wide[DATA_W];
    clampVal = clampNeg ? MIN_NEG : MAX_POS;
    satHit   = stb.doArith && stb.satEn && ovRaw;
  end

  always_comb begin
    unique case (stb.logicSel)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOTA: logicRes = ~opA;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    nextFlags  = flagsQ;
    nextResult = resultQ;
    if (stb.valid && stb.doArith) begin
      nextFlags[FZ]   = (rawArith == '0);
      nextFlags[FS]   = rawArith[MSB];
      nextFlags[FOV]  = ovRaw;
      nextFlags[FCY]  = cyRaw;
      nextFlags[FSAT] = flagsQ[FSAT] | satHit;
      if (stb.writeRes) nextResult = satHit ? clampVal : rawArith;
    end else if (stb.valid && stb.doLogic) begin
      nextFlags[FZ]  = (logicRes == '0);
      nextFlags[FS]  = stb.zOnly ? 1'b0 : logicRes[MSB];
      nextFlags[FOV] = 1'b0;
      if (stb.writeRes) nextResult = logicRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      wenQ    <= 1'b0;
      flagsQ  <= '0;
      satHitQ <= 1'b0;
    end else begin
      resultQ <= nextResult;
      wenQ    <= stb.valid && stb.writeRes;
      flagsQ  <= nextFlags;
      satHitQ <= stb.valid && stb.writeRes && satHit;
    end
  end

  // R5: a clamped write lands on one of the two signed extremes
  p_clamp_extreme_r5: assert property (@(posedge clk) disable iff (!rstN)
    satHitQ |-> (resultQ == MAX_POS || resultQ == MIN_NEG));
  // R6: saturation bit never falls while out of reset
  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ[FSAT] |=> flagsQ[FSAT]);
  // R7: logical operations leave overflow cleared
  p_logic_ov_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.doLogic) |=> !flagsQ[FOV]);
  // R10: idle cycles keep the status word and raise no write
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.valid |=> ($stable(flagsQ) && !wenQ));
  // R8: zero-extended AND immediate clears sign
  p_andi_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.zOnly) |=> !flagsQ[FS]);
endmodule

// File: rtl/sat_flag_alu.sv
module sat_flag_alu
  import satalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [1:0]        immMode,
  output logic [DATA_W-1:0] resultOut,
  output logic              writeEn,
  output logic [FLAG_W-1:0] flagsOut
);
  strobe_t stb;

  alu_ctrl uCtrl (
    .inValid (inValid),
    .opCode  (opCode),
    .immMode (immMode),
    .stb     (stb)
  );

  alu_dpath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHORT_W(SHORT_W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .srcA    (srcA),
    .srcB    (srcB),
    .immVal  (immVal),
    .immMode (immMode),
    .resultQ (resultOut),
    .wenQ    (writeEn),
    .flagsQ  (flagsOut)
  );

  // R2: compare never requests a write and keeps the result
  p_cmp_nowrite_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == OP_CMP) |=> (!writeEn && $stable(resultOut)));
  // R1: a write strobe follows a captured operation
  p_wen_after_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> $past(inValid));
endmodule

// File: tb/sat_flag_alu_test.sv
`timescale 1ns/1ps
module sat_flag_alu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [15:0] immVal = '0;
  logic [1:0]  immMode = '0;
  logic [31:0] resultOut;
  logic        writeEn;
  logic [4:0]  flagsOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sat_flag_alu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .immVal(immVal), .immMode(immMode),
    .resultOut(resultOut), .writeEn(writeEn), .flagsOut(flagsOut)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [1:0]  mode;
    logic [15:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        wen;
    logic [4:0]  flg;   // {SAT,CY,OV,S,Z}
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  4'h0, 2'd0, 16'h0000, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b1, 5'b00000}, // R1 add
    '{4'd4,  4'h0, 2'd0, 16'h0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 5'b01001}, // R4 carry out
    '{4'd1,  4'h1, 2'd0, 16'h0000, 32'h00000001, 32'h00000003, 32'h00000002, 1'b1, 5'b00000}, // R1 sub
    '{4'd4,  4'h1, 2'd0, 16'h0000, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 1'b1, 5'b01010}, // R4 borrow
    '{4'd1,  4'h2, 2'd0, 16'h0000, 32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 5'b00000}, // R1 rsub
    '{4'd2,  4'h3, 2'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h00000002, 1'b0, 5'b01110}, // R2 R3 cmp
    '{4'd9,  4'h0, 2'd1, 16'h001F, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1, 5'b01001}, // R9 sx5
    '{4'd9,  4'h0, 2'd2, 16'h8000, 32'h12345678, 32'h00010000, 32'h00008000, 1'b1, 5'b01000}, // R9 sx16
    '{4'd7,  4'h8, 2'd3, 16'h8000, 32'h12345678, 32'h80000000, 32'h80008000, 1'b1, 5'b01010}, // R7 R9 or zx16
    '{4'd7,  4'h9, 2'd0, 16'h0000, 32'hFFFF0000, 32'hFFFF0000, 32'h00000000, 1'b1, 5'b01001}, // R7 xor
    '{4'd5,  4'h4, 2'd0, 16'h0000, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1, 5'b10110}, // R5 R3 sadd
    '{4'd6,  4'h7, 2'd0, 16'h0000, 32'h000000F0, 32'h0000000F, 32'h00000000, 1'b1, 5'b10001}, // R6 and
    '{4'd5,  4'h5, 2'd0, 16'h0000, 32'h00000001, 32'h80000000, 32'h80000000, 1'b1, 5'b10100}, // R5 ssub
    '{4'd5,  4'h6, 2'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1, 5'b10100}, // R5 srsub neg
    '{4'd5,  4'h6, 2'd0, 16'h0000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1, 5'b11110}, // R5 srsub pos
    '{4'd8,  4'h7, 2'd3, 16'h00FF, 32'h12345678, 32'h12345600, 32'h00000000, 1'b1, 5'b11001}, // R8 andi
    '{4'd6,  4'h4, 2'd0, 16'h0000, 32'h00000002, 32'h00000003, 32'h00000005, 1'b1, 5'b10000}, // R6 clean sadd
    '{4'd7,  4'hA, 2'd0, 16'h0000, 32'h00000000, 32'h5A5A5A5A, 32'hFFFFFFFF, 1'b1, 5'b10010}, // R7 not
    '{4'd7,  4'hB, 2'd0, 16'h0000, 32'h0000000F, 32'h000000F0, 32'hFFFFFFFF, 1'b0, 5'b10001}, // R7 tst
    '{4'd10, 4'hF, 2'd0, 16'h0000, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 1'b0, 5'b10001}, // R10 unused
    '{4'd2,  4'h3, 2'd1, 16'h0010, 32'h00000000, 32'h00000005, 32'hFFFFFFFF, 1'b0, 5'b11000}  // R2 cmp sx5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11 result", resultOut, 32'h0);
    check("R11 wen", {31'b0, writeEn}, 32'h0);
    check("R11 flags", {27'b0, flagsOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      opCode = VEC[i].op; immMode = VEC[i].mode; immVal = VEC[i].imm;
      srcA = VEC[i].a; srcB = VEC[i].b; inValid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d result", VEC[i].req, i), resultOut, VEC[i].res);
      check($sformatf("R%0d vec%0d wen", VEC[i].req, i), {31'b0, writeEn}, {31'b0, VEC[i].wen});
      check($sformatf("R%0d vec%0d flags", VEC[i].req, i), {27'b0, flagsOut}, {27'b0, VEC[i].flg});
      inValid = 1'b0;
      @(negedge clk);
      check($sformatf("R1 vec%0d wen drop", i), {31'b0, writeEn}, 32'h0);
    end

    // R10: idle cycles with valid low and busy inputs change nothing
    opCode = 4'h4; srcA = 32'h7FFFFFFF; srcB = 32'h7FFFFFFF;
    repeat (3) @(negedge clk);
    check("R10 idle flags", {27'b0, flagsOut}, {27'b0, 5'b11000});
    check("R10 idle result", resultOut, 32'hFFFFFFFF);
    check("R10 idle wen", {31'b0, writeEn}, 32'h0);

    // R6 R11: only reset clears the sticky saturation bit
    rstN = 1'b0;
    @(negedge clk);
    check("R6 R11 flags after reset", {27'b0, flagsOut}, 32'h0);
    check("R11 result after reset", resultOut, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule